// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Address-Frame Filter

This block turns an asynchronous serial line into parallel words. It takes a baud tick from an external divider. The tick runs at sixteen times the bit rate in normal speed and at eight times the bit rate in double speed. Each frame carries 5 to 9 data bits, sent least significant bit first, and may carry a parity bit after the data. The receiver examines the first stop bit only. Every bit, the start bit included, is decided by a two-of-three vote of samples taken around the bit centre.

Each frame carries a type flag. With 9 data bits the flag is the ninth bit. With 5 to 8 data bits the flag is the value of the first stop bit. A flag of one marks an address frame and a flag of zero marks a data frame. When the host sets the filter input, only address frames reach the output register and data frames vanish without a strobe. A host listening on a shared multi-drop line keeps the filter on until it sees its own address, then clears the filter to take the data that follows. The block does not compare addresses itself.

Top module: `uart_rx_mpfilter`

## Requirements
- R1: After reset, rx_valid, rx_word, rx_type, rx_frame_err and rx_parity_err are all 0.
- R2: cfg_data_bits selects the number of data bits: codes 5, 6, 7, 8 and 9 give that many bits. Data arrive LSB first and are placed right-justified in rx_word, and the unused upper bits read 0.
- R3: A low level on the line while the receiver is idle opens a start bit. If the vote at the centre of that start bit is high, the start is dropped as a glitch and no frame is delivered.
- R4: rx_type is the frame-type flag. With 9 data bits it equals the ninth data bit, which is also rx_word[8]. With 5 to 8 data bits it equals the value sampled for the first stop bit.
- R5: With filt_en = 0, every frame is delivered, and its type flag is reported on rx_type.
- R6: With filt_en = 1, a frame whose type flag is 0 produces no rx_valid and leaves all outputs unchanged. A frame whose type flag is 1 is delivered.
- R7: A low first stop bit sets rx_frame_err on the delivered frame only when filt_en = 0. With filt_en = 1, rx_frame_err is never set.
- R8: cfg_parity_en = 1 adds one parity bit after the data. With cfg_parity_odd = 0 the data bits plus the parity bit hold an even number of ones. With cfg_parity_odd = 1 they hold an odd number. A mismatch sets rx_parity_err, and the frame is still delivered.
- R9: rx_valid is high for exactly one clock per delivered frame. The output fields hold their values until the next delivery.
- R10: With cfg_double_speed = 0 (16 ticks per bit), frames are decoded correctly when the sender's rate is off by ±3.0% with 5 data+parity bits, and by ±1.5% with 10 data+parity bits.
- R11: With cfg_double_speed = 1 (8 ticks per bit), frames are decoded correctly when the sender's rate is off by ±2.5% with 5 data+parity bits, and by ±1.0% with 10 data+parity bits.
- R12: Only the first stop bit is examined. A new start bit may follow it directly, and both frames are delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-clock pulse at 16x (or 8x) the bit rate |
| rxd | input | 1 | Serial line, idle high, asynchronous |
| cfg_data_bits | input | 4 | Data bits per frame, 5 to 9 |
| cfg_parity_en | input | 1 | Parity bit present |
| cfg_parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_double_speed | input | 1 | 1 = 8 ticks per bit, 0 = 16 ticks per bit |
| filt_en | input | 1 | Deliver address frames only |
| rx_valid | output | 1 | One-clock strobe for a delivered frame |
| rx_word | output | 9 | Received data, right-justified |
| rx_type | output | 1 | Frame-type flag of the delivered frame |
| rx_frame_err | output | 1 | First stop bit low (filter off only) |
| rx_parity_err | output | 1 | Parity mismatch |

## Verification
The parity check and the stop-bit check both report in the same delivery cycle, so one frame can raise both flags. The bench sends an 8-bit frame with the parity bit inverted and the stop bit held low, with the filter off. It then expects a single rx_valid pulse that carries both error flags and a type flag of zero. A second collision is between the filter and the stop check. The bench sends a 9-bit address frame with a low stop bit while filtering is on. It expects the frame to be delivered with the framing flag clear.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   localparam int WORD_W = 9;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PARITY,
      ST_STOP
   } rx_state_e;

   // index of the last data bit, clamped to the 5..9 range
   function automatic logic [3:0] last_bit_idx(input logic [3:0] nbits);
      if (nbits < 4'd5)      return 4'd4;
      else if (nbits > 4'd9) return 4'd8;
      else                   return nbits - 4'd1;
   endfunction

   function automatic logic vote3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int  STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RESET_VAL;
               else        chain[0] <= d_async;
            end
         end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= RESET_VAL;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
   import uart_rx_pkg::*;
#(
   parameter int OVS_NORMAL = 16,
   parameter int OVS_DOUBLE = 8,
   parameter bit MAJORITY   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic double_speed,
   input  logic restart,
   input  logic line,
   output logic vote_stb,
   output logic vote_val
);
   localparam int CW = $clog2(OVS_NORMAL);

   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_last;
   logic [CW-1:0] cnt_half;

   assign cnt_last = double_speed ? CW'(OVS_DOUBLE - 1) : CW'(OVS_NORMAL - 1);
   assign cnt_half = double_speed ? CW'(OVS_DOUBLE / 2) : CW'(OVS_NORMAL / 2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt <= '0;
      else if (tick && restart)           cnt <= '0;
      else if (tick && cnt >= cnt_last)   cnt <= '0;
      else if (tick)                      cnt <= cnt + 1'b1;
   end

   // the vote closes one tick after the centre sample
   assign vote_stb = tick && !restart && (cnt == cnt_half + 1'b1);

   generate
      if (MAJORITY) begin : g_vote3
         logic smp_early, smp_mid;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               smp_early <= 1'b1;
               smp_mid   <= 1'b1;
            end else if (tick) begin
               if (cnt == cnt_half - 1'b1) smp_early <= line;
               if (cnt == cnt_half)        smp_mid   <= line;
            end
         end
         assign vote_val = vote3(smp_early, smp_mid, line);
      end else begin : g_single
         logic smp_mid;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        smp_mid <= 1'b1;
            else if (tick && cnt == cnt_half)  smp_mid <= line;
         end
         assign vote_val = smp_mid;
      end
   endgenerate

endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
   import uart_rx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line,
   input  logic              vote_stb,
   input  logic              vote_val,
   input  logic [3:0]        cfg_data_bits,
   input  logic              cfg_parity_en,
   input  logic              cfg_parity_odd,
   output logic              restart,
   output logic              frm_done,
   output logic [WORD_W-1:0] frm_word,
   output logic              frm_type,
   output logic              frm_stop,
   output logic              frm_par_err
);
   rx_state_e         state;
   logic [3:0]        bit_idx;
   logic [3:0]        idx_last;
   logic [WORD_W-1:0] shreg;
   logic              par_bit;
   logic              seen_high;

   assign idx_last = last_bit_idx(cfg_data_bits);
   assign restart  = (state == ST_IDLE) && tick && seen_high && !line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         bit_idx     <= '0;
         shreg       <= '0;
         par_bit     <= 1'b0;
         seen_high   <= 1'b0;
         frm_done    <= 1'b0;
         frm_word    <= '0;
         frm_type    <= 1'b0;
         frm_stop    <= 1'b0;
         frm_par_err <= 1'b0;
      end else begin
         frm_done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (line) seen_high <= 1'b1;
               if (restart) begin
                  state     <= ST_START;
                  seen_high <= 1'b0;
                  shreg     <= '0;
                  bit_idx   <= '0;
               end
            end
            ST_START: if (vote_stb) state <= vote_val ? ST_IDLE : ST_DATA;
            ST_DATA: if (vote_stb) begin
               shreg[bit_idx] <= vote_val;
               bit_idx        <= bit_idx + 1'b1;
               if (bit_idx == idx_last)
                  state <= cfg_parity_en ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: if (vote_stb) begin
               par_bit <= vote_val;
               state   <= ST_STOP;
            end
            ST_STOP: if (vote_stb) begin
               frm_done    <= 1'b1;
               frm_word    <= shreg;
               frm_stop    <= vote_val;
               frm_type    <= (idx_last == 4'd8) ? shreg[8] : vote_val;
               frm_par_err <= cfg_parity_en && (par_bit != ((^shreg) ^ cfg_parity_odd));
               state       <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // a finished frame always follows a bit decision from the sampler
   p_done_after_vote_r12: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done |-> $past(vote_stb));

endmodule

// File: rtl/uart_rx_mpfilter.sv
module uart_rx_mpfilter
   import uart_rx_pkg::*;
#(
   parameter int OVS_NORMAL  = 16,
   parameter int OVS_DOUBLE  = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit MAJORITY    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              rxd,
   input  logic [3:0]        cfg_data_bits,
   input  logic              cfg_parity_en,
   input  logic              cfg_parity_odd,
   input  logic              cfg_double_speed,
   input  logic              filt_en,
   output logic              rx_valid,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_type,
   output logic              rx_frame_err,
   output logic              rx_parity_err
);
   generate
      if (OVS_DOUBLE < 4 || OVS_NORMAL != 2 * OVS_DOUBLE ||
          (OVS_NORMAL & (OVS_NORMAL - 1)) != 0) begin : g_bad_ovs
         $error("oversampling ratios must be powers of two, double = normal/2 >= 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              line_s;
   logic              restart;
   logic              vote_stb, vote_val;
   logic              frm_done, frm_type, frm_stop, frm_par_err;
   logic [WORD_W-1:0] frm_word;
   logic              deliver;

   uart_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (rxd),
      .q_sync  (line_s)
   );

   uart_rx_sampler #(
      .OVS_NORMAL (OVS_NORMAL),
      .OVS_DOUBLE (OVS_DOUBLE),
      .MAJORITY   (MAJORITY)
   ) u_sampler (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (baud_tick),
      .double_speed (cfg_double_speed),
      .restart      (restart),
      .line         (line_s),
      .vote_stb     (vote_stb),
      .vote_val     (vote_val)
   );

   uart_rx_framer u_framer (
      .clk            (clk),
      .rst_n          (rst_n),
      .tick           (baud_tick),
      .line           (line_s),
      .vote_stb       (vote_stb),
      .vote_val       (vote_val),
      .cfg_data_bits  (cfg_data_bits),
      .cfg_parity_en  (cfg_parity_en),
      .cfg_parity_odd (cfg_parity_odd),
      .restart        (restart),
      .frm_done       (frm_done),
      .frm_word       (frm_word),
      .frm_type       (frm_type),
      .frm_stop       (frm_stop),
      .frm_par_err    (frm_par_err)
   );

   assign deliver = frm_done && (!filt_en || frm_type);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_valid      <= 1'b0;
         rx_word       <= '0;
         rx_type       <= 1'b0;
         rx_frame_err  <= 1'b0;
         rx_parity_err <= 1'b0;
      end else begin
         rx_valid <= deliver;
         if (deliver) begin
            rx_word       <= frm_word;
            rx_type       <= frm_type;
            rx_frame_err  <= !frm_stop && !filt_en;
            rx_parity_err <= frm_par_err;
         end
      end
   end

   p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   p_word_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> $stable(rx_word) && $stable(rx_type));

   p_filter_addr_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && $past(filt_en) |-> rx_type);

   p_ferr_filter_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && rx_frame_err |-> !$past(filt_en));

endmodule

// File: tb/uart_rx_mpfilter_tb_top.sv
`timescale 1ns/1ps
module uart_rx_mpfilter_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       rxd = 1'b1;
   logic [3:0] cfg_data_bits = 4'd8;
   logic       cfg_parity_en = 1'b0;
   logic       cfg_parity_odd = 1'b0;
   logic       cfg_double_speed = 1'b0;
   logic       filt_en = 1'b0;
   logic       rx_valid;
   logic [8:0] rx_word;
   logic       rx_type, rx_frame_err, rx_parity_err;

   int n_checks = 0;
   int n_fail   = 0;
   int n_valid  = 0;

   localparam real BIT_NS_N = 128.0;  // 16 ticks x 2 clocks x 4 ns
   localparam real BIT_NS_D = 64.0;

   always #2 clk = ~clk;

   uart_rx_mpfilter dut_i (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
      .cfg_data_bits(cfg_data_bits), .cfg_parity_en(cfg_parity_en),
      .cfg_parity_odd(cfg_parity_odd), .cfg_double_speed(cfg_double_speed),
      .filt_en(filt_en), .rx_valid(rx_valid), .rx_word(rx_word),
      .rx_type(rx_type), .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err)
   );

   // tick every second clock, driven away from the rising edge
   initial begin
      forever begin
         @(negedge clk) baud_tick = 1'b1;
         @(negedge clk) baud_tick = 1'b0;
      end
   end

   always @(negedge clk) if (rx_valid) n_valid++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [8:0] d, input int nb, input bit pe, input bit podd,
                       input bit pflip, input bit stopv, input real bns, input int idle_bits);
      logic [8:0] dm;
      dm = d & ((9'h1 << nb) - 9'h1);
      rxd = 1'b0; #(bns);
      for (int i = 0; i < nb; i++) begin rxd = dm[i]; #(bns); end
      if (pe) begin rxd = (^dm) ^ podd ^ pflip; #(bns); end
      rxd = stopv; #(bns);
      rxd = 1'b1;
      for (int i = 0; i < idle_bits; i++) #(bns);
   endtask

   task automatic expect_frame(input string req, input int v0, input logic [8:0] w,
                               input bit t, input bit fe, input bit pe);
      chk({req, " strobe count"}, n_valid, v0 + 1);
      chk({req, " word"}, rx_word, w);
      chk({req, " type"}, rx_type, t);
      chk({req, " frame_err"}, rx_frame_err, fe);
      chk({req, " parity_err"}, rx_parity_err, pe);
   endtask

   task automatic expect_drop(input string req, input int v0, input logic [8:0] w_prev);
      chk({req, " no strobe"}, n_valid, v0);
      chk({req, " word held"}, rx_word, w_prev);
   endtask

   task automatic t_reset;
      chk("R1 valid", rx_valid, 0);
      chk("R1 word", rx_word, 0);
      chk("R1 type", rx_type, 0);
      chk("R1 ferr", rx_frame_err, 0);
      chk("R1 perr", rx_parity_err, 0);
   endtask

   task automatic t_widths;
      int v0;
      cfg_parity_en = 0; filt_en = 0;
      cfg_data_bits = 4'd8; v0 = n_valid;
      send(9'h0A5, 8, 0, 0, 0, 1, BIT_NS_N, 2);
      expect_frame("R2 8-bit", v0, 9'h0A5, 1, 0, 0);
      cfg_data_bits = 4'd5; v0 = n_valid;
      send(9'h1FF, 5, 0, 0, 0, 1, BIT_NS_N, 2);
      expect_frame("R2 5-bit", v0, 9'h01F, 1, 0, 0);
      cfg_data_bits = 4'd7; v0 = n_valid;
      send(9'h055, 7, 0, 0, 0, 1, BIT_NS_N, 2);
      expect_frame("R2 7-bit", v0, 9'h055, 1, 0, 0);
   endtask

   task automatic t_type_nofilter;
      int v0;
      filt_en = 0; cfg_parity_en = 0;
      cfg_data_bits = 4'd9; v0 = n_valid;
      send(9'h13C, 9, 0, 0, 0, 1, BIT_NS_N, 2);
      expect_frame("R4 9-bit address", v0, 9'h13C, 1, 0, 0);
      v0 = n_valid;
      send(9'h03C, 9, 0, 0, 0, 1, BIT_NS_N, 2);
      expect_frame("R5 9-bit data delivered", v0, 9'h03C, 0, 0, 0);
      cfg_data_bits = 4'd8; v0 = n_valid;
      send(9'h081, 8, 0, 0, 0, 0, BIT_NS_N, 2);
      expect_frame("R7 low stop filter off", v0, 9'h081, 0, 1, 0);
   endtask

   task automatic t_filter;
      int v0;
      logic [8:0] wp;
      filt_en = 1; cfg_parity_en = 0; cfg_data_bits = 4'd8;
      v0 = n_valid;
      send(9'h042, 8, 0, 0, 0, 1, BIT_NS_N, 2);
      expect_frame("R6 8-bit address kept", v0, 9'h042, 1, 0, 0);
      v0 = n_valid; wp = rx_word;
      send(9'h0F0, 8, 0, 0, 0, 0, BIT_NS_N, 2);
      expect_drop("R6 8-bit data dropped", v0, wp);
      chk("R7 no ferr under filter", rx_frame_err, 0);
      cfg_data_bits = 4'd9; v0 = n_valid; wp = rx_word;
      send(9'h0AA, 9, 0, 0, 0, 1, BIT_NS_N, 2);
      expect_drop("R6 9-bit data dropped", v0, wp);
      v0 = n_valid;
      send(9'h1AA, 9, 0, 0, 0, 0, BIT_NS_N, 2);
      expect_frame("R7 9-bit addr low stop filtered", v0, 9'h1AA, 1, 0, 0);
      filt_en = 0;
   endtask

   task automatic t_parity;
      int v0;
      filt_en = 0; cfg_data_bits = 4'd8; cfg_parity_en = 1;
      cfg_parity_odd = 0; v0 = n_valid;
      send(9'h0B3, 8, 1, 0, 0, 1, BIT_NS_N, 2);
      expect_frame("R8 even ok", v0, 9'h0B3, 1, 0, 0);
      cfg_parity_odd = 1; v0 = n_valid;
      send(9'h0B3, 8, 1, 1, 0, 1, BIT_NS_N, 2);
      expect_frame("R8 odd ok", v0, 9'h0B3, 1, 0, 0);
      v0 = n_valid;
      send(9'h017, 8, 1, 1, 1, 1, BIT_NS_N, 2);
      expect_frame("R8 odd bad", v0, 9'h017, 1, 0, 1);
      cfg_parity_odd = 0; v0 = n_valid;
      send(9'h0C4, 8, 1, 0, 1, 0, BIT_NS_N, 2);
      expect_frame("R8 R7 parity and framing together", v0, 9'h0C4, 0, 1, 1);
      cfg_parity_en = 0;
   endtask

   task automatic t_glitch;
      int v0;
      logic [8:0] wp;
      filt_en = 0; cfg_data_bits = 4'd8; v0 = n_valid; wp = rx_word;
      rxd = 1'b0; #16; rxd = 1'b1;
      #(BIT_NS_N * 12);
      expect_drop("R3 start glitch", v0, wp);
      v0 = n_valid;
      send(9'h066, 8, 0, 0, 0, 1, BIT_NS_N, 2);
      expect_frame("R3 frame after glitch", v0, 9'h066, 1, 0, 0);
   endtask

   task automatic t_back_to_back;
      int v0;
      filt_en = 0; cfg_data_bits = 4'd8; v0 = n_valid;
      send(9'h0D2, 8, 0, 0, 0, 1, BIT_NS_N, 0);
      send(9'h02D, 8, 0, 0, 0, 1, BIT_NS_N, 2);
      chk("R12 two strobes", n_valid, v0 + 2);
      chk("R12 second word", rx_word, 9'h02D);
      chk("R9 single-cycle strobe", rx_valid, 0);
   endtask

   task automatic t_tolerance(input bit dbl, input string req);
      real nom, e5, e10;
      int v0;
      cfg_double_speed = dbl; filt_en = 0;
      nom = dbl ? BIT_NS_D : BIT_NS_N;
      e5  = dbl ? 0.025 : 0.030;
      e10 = dbl ? 0.010 : 0.015;
      for (int s = 0; s < 2; s++) begin
         real f5, f10;
         f5  = (s == 0) ? 1.0 + e5  : 1.0 - e5;
         f10 = (s == 0) ? 1.0 + e10 : 1.0 - e10;
         cfg_data_bits = 4'd5; cfg_parity_en = 0; v0 = n_valid;
         send(9'h015, 5, 0, 0, 0, 1, nom * f5, 2);
         expect_frame({req, " 5 bits"}, v0, 9'h015, 1, 0, 0);
         cfg_data_bits = 4'd9; cfg_parity_en = 1; cfg_parity_odd = 0; v0 = n_valid;
         send(9'h1A6, 9, 1, 0, 0, 1, nom * f10, 2);
         expect_frame({req, " 10 bits"}, v0, 9'h1A6, 1, 0, 0);
      end
      cfg_parity_en = 0; cfg_double_speed = 0;
   endtask

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      t_widths();
      t_type_nofilter();
      t_filter();
      t_parity();
      t_glitch();
      t_back_to_back();
      t_tolerance(1'b0, "R10");
      t_tolerance(1'b1, "R11");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule